// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block maps a physical memory address to one of eight DRAM rows. Software programs eight byte-wide boundary registers over a plain register port. Each register holds a running total, in 32 MB units, of the memory in its own row and in every row below it. So each register gives the upper limit of its row, and the register of the row below gives the lower limit. For each presented address the block compares the address's 32 MB unit index against all eight limits at once. One cycle later it reports the selected row as a one-hot vector and as an index, or it raises a miss flag when the address lies above the populated memory.

The same register port reaches a miscellaneous control byte. Only one bit of that byte is implemented: a global aperture enable. While the enable is clear, an incoming aperture-hit indication is blocked, whichever requester raised it. A double-data-rate mode input is also checked. In that mode the four upper rows must repeat the limit of row 3, which leaves them empty, and any register that breaks this rule raises a configuration-error flag.

The decode path is a three-state outcome register:
- DEC_IDLE: no address was presented in the previous cycle.
- DEC_HIT: a row matched, and its index is held.
- DEC_MISS: no row matched.

Every cycle the next state is chosen from the current input, so every state can reach every state. No valid address goes to DEC_IDLE. A valid address with a matching row goes to DEC_HIT. A valid address with no matching row goes to DEC_MISS.

Top module: `row_limit_decoder`

## Requirements
- R1: After reset, every row boundary register and the control byte read back 00h, row_valid is low, and aper_hit_out is low.
- R2: A write to offset 60h+i (i = 0..7, in row order) stores the byte as row i's boundary. It reads back from the same offset from the next cycle on.
- R3: At offset 51h only bit 1 (aperture enable) is stored. The other bits of that byte read 0 whatever was written. Offsets that are neither 51h nor 60h..67h read 00h, and writes to them change no register.
- R4: A valid address presented at a clock edge produces row_valid high with that address's result after the next clock edge, and back-to-back addresses produce back-to-back results.
- R5: With unit index u = mem_addr[31:25], the selected row is the lowest row i whose boundary is strictly greater than u. row_hit has only bit i set and row_idx equals i. Address bits 24:0 have no effect.
- R6: A row whose boundary equals the boundary of the row below it (for row 0: a boundary of 0) is never selected. The decode falls through to the next row above it.
- R7: When no boundary is greater than u, row_miss is high, row_hit is all zero and row_idx is 0.
- R8: aper_hit_out follows aper_hit_in while the aperture enable bit is 1, and is 0 while that bit is 0.
- R9: cfg_err is high exactly when ddr_mode is high and at least one of rows 4..7 holds a boundary different from row 3.
- R10: A cycle with addr_valid low yields row_valid, row_miss and all row_hit bits low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| addr_valid | input | 1 | mem_addr is valid this cycle |
| mem_addr | input | 32 | Physical address to decode |
| ddr_mode | input | 1 | Double-data-rate mode flag for the consistency check |
| aper_hit_in | input | 1 | Aperture hit from the address path |
| row_hit | output | 8 | One-hot selected row |
| row_idx | output | 3 | Encoded selected row |
| row_valid | output | 1 | Decode result valid |
| row_miss | output | 1 | Address above all populated rows |
| aper_hit_out | output | 1 | Aperture hit gated by the enable bit |
| cfg_err | output | 1 | Upper rows disagree with row 3 in DDR mode |

## Verification
The first set of addresses is decoded against a layout in DDR form: limits 2, 4, 4, 7 and four copies of 7. Addresses sit on both sides of each limit, which separates the strict comparison from a greater-or-equal one. An address falls into the empty row 2 and must land in row 3, which shows that empty rows are skipped. Two addresses above the top limit must miss. A second, mostly ascending layout with an empty row 0 and a wide row 7 tests the low and high ends, and garbage in the low 25 address bits shows that only the unit index counts. Directed tests then cover reserved and unmapped offsets, the aperture gate in both enable states, and the error flag with the mode on and off.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

    // Outcome of the most recent decode slot
    typedef enum logic [1:0] {
        DEC_IDLE = 2'd0,
        DEC_HIT  = 2'd1,
        DEC_MISS = 2'd2
    } dec_state_e;

    // True when offset a lies in [base, base+n)
    function automatic logic in_window(input logic [7:0] a,
                                       input logic [7:0] base,
                                       input int         n);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
    endfunction

endpackage

// File: rtl/rowdec_regfile.sv
module rowdec_regfile #(
    parameter int               NUM_ROWS = 8,
    parameter int               DATA_W   = 8,
    parameter int               RA_W     = 8,
    parameter logic [RA_W-1:0]  ROW_BASE = 8'h60,
    parameter logic [RA_W-1:0]  MISC_OFS = 8'h51,
    parameter int               APEN_BIT = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [RA_W-1:0]            addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_ROWS*DATA_W-1:0] bnd_flat,
    output logic                       apen
);

    logic [DATA_W-1:0] bnd_q [NUM_ROWS];
    logic              apen_q;

    // One byte register per row, each at its own offset
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        localparam logic [RA_W-1:0] OFS = RA_W'(int'(ROW_BASE) + r);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bnd_q[r] <= '0;
            end else if (wr_en && (addr == OFS)) begin
                bnd_q[r] <= wdata;
            end
        end

        assign bnd_flat[r*DATA_W +: DATA_W] = bnd_q[r];
    end

    // Only the enable bit of the control byte is kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apen_q <= 1'b0;
        end else if (wr_en && (addr == MISC_OFS)) begin
            apen_q <= wdata[APEN_BIT];
        end
    end

    assign apen = apen_q;

    always_comb begin
        rdata = '0;
        if (addr == MISC_OFS) begin
            rdata[APEN_BIT] = apen_q;
        end
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (addr == RA_W'(int'(ROW_BASE) + r)) begin
                rdata = bnd_q[r];
            end
        end
    end

endmodule

// File: rtl/rowdec_compare.sv
module rowdec_compare
    import rowdec_pkg::*;
#(
    parameter int NUM_ROWS   = 8,
    parameter int BND_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 25,
    parameter int IDX_W      = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      addr_valid,
    input  logic [ADDR_W-1:0]         mem_addr,
    input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
    output logic [NUM_ROWS-1:0]       row_hit,
    output logic [IDX_W-1:0]          row_idx,
    output logic                      row_valid,
    output logic                      row_miss
);

    localparam int UNIT_W = ADDR_W - UNIT_SHIFT;
    localparam int CMP_W  = (UNIT_W > BND_W) ? UNIT_W : BND_W;

    logic [CMP_W-1:0]    unit_ext;
    logic [NUM_ROWS-1:0] above;
    logic                found;
    logic [IDX_W-1:0]    found_idx;

    dec_state_e          state_q, state_d;
    logic [IDX_W-1:0]    idx_q, idx_d;

    assign unit_ext = CMP_W'(mem_addr[ADDR_W-1:UNIT_SHIFT]);

    // Parallel compare of the unit index against every limit
    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_cmp
        assign above[i] = CMP_W'(bnd_flat[i*BND_W +: BND_W]) > unit_ext;
    end

    // Lowest row whose limit exceeds the index wins
    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (above[i]) begin
                found     = 1'b1;
                found_idx = IDX_W'(i);
            end
        end
    end

    // Next-state choice
    always_comb begin
        state_d = DEC_IDLE;
        idx_d   = '0;
        if (addr_valid) begin
            if (found) begin
                state_d = DEC_HIT;
                idx_d   = found_idx;
            end else begin
                state_d = DEC_MISS;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs from state
    always_comb begin
        row_hit   = '0;
        row_idx   = '0;
        row_valid = 1'b0;
        row_miss  = 1'b0;
        unique case (state_q)
            DEC_IDLE: begin
                row_valid = 1'b0;
            end
            DEC_HIT: begin
                row_valid = 1'b1;
                row_idx   = idx_q;
                row_hit   = NUM_ROWS'(1) << idx_q;
            end
            DEC_MISS: begin
                row_valid = 1'b1;
                row_miss  = 1'b1;
            end
            default: begin
                row_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rowdec_ddr_check.sv
module rowdec_ddr_check #(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 8,
    parameter int REF_ROW  = 3
) (
    input  logic                      ddr_mode,
    input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
    output logic                      cfg_err
);

    logic [NUM_ROWS-1:0] differs;
    logic [BND_W-1:0]    ref_bnd;

    assign ref_bnd = bnd_flat[REF_ROW*BND_W +: BND_W];

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_diff
        if (i > REF_ROW) begin : g_upper
            assign differs[i] = bnd_flat[i*BND_W +: BND_W] != ref_bnd;
        end else begin : g_lower
            assign differs[i] = 1'b0;
        end
    end

    assign cfg_err = ddr_mode && (|differs);

endmodule

// File: rtl/row_limit_decoder.sv
module row_limit_decoder #(
    parameter int          NUM_ROWS    = 8,
    parameter int          BND_W       = 8,
    parameter int          ADDR_W      = 32,
    parameter int          UNIT_SHIFT  = 25,
    parameter int          RA_W        = 8,
    parameter logic [7:0]  ROW_BASE    = 8'h60,
    parameter logic [7:0]  MISC_OFS    = 8'h51,
    parameter int          APEN_BIT    = 1,
    parameter int          DDR_REF_ROW = 3,
    localparam int         IDX_W       = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [RA_W-1:0]     reg_addr,
    input  logic [BND_W-1:0]    reg_wdata,
    output logic [BND_W-1:0]    reg_rdata,
    input  logic                addr_valid,
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic                ddr_mode,
    input  logic                aper_hit_in,
    output logic [NUM_ROWS-1:0] row_hit,
    output logic [IDX_W-1:0]    row_idx,
    output logic                row_valid,
    output logic                row_miss,
    output logic                aper_hit_out,
    output logic                cfg_err
);

    logic [NUM_ROWS*BND_W-1:0] bnd_flat;
    logic                      apen;

    rowdec_regfile #(
        .NUM_ROWS (NUM_ROWS),
        .DATA_W   (BND_W),
        .RA_W     (RA_W),
        .ROW_BASE (RA_W'(ROW_BASE)),
        .MISC_OFS (RA_W'(MISC_OFS)),
        .APEN_BIT (APEN_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .bnd_flat (bnd_flat),
        .apen     (apen)
    );

    rowdec_compare #(
        .NUM_ROWS   (NUM_ROWS),
        .BND_W      (BND_W),
        .ADDR_W     (ADDR_W),
        .UNIT_SHIFT (UNIT_SHIFT),
        .IDX_W      (IDX_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (addr_valid),
        .mem_addr   (mem_addr),
        .bnd_flat   (bnd_flat),
        .row_hit    (row_hit),
        .row_idx    (row_idx),
        .row_valid  (row_valid),
        .row_miss   (row_miss)
    );

    rowdec_ddr_check #(
        .NUM_ROWS (NUM_ROWS),
        .BND_W    (BND_W),
        .REF_ROW  (DDR_REF_ROW)
    ) u_ddr (
        .ddr_mode (ddr_mode),
        .bnd_flat (bnd_flat),
        .cfg_err  (cfg_err)
    );

    assign aper_hit_out = aper_hit_in && apen;

endmodule

// File: rtl/rowdec_checker.sv
module rowdec_checker #(
    parameter int          NUM_ROWS = 8,
    parameter int          BND_W    = 8,
    parameter int          RA_W     = 8,
    parameter logic [7:0]  ROW_BASE = 8'h60,
    parameter int          IDX_W    = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_wr_en,
    input logic [RA_W-1:0]           reg_addr,
    input logic [BND_W-1:0]          reg_wdata,
    input logic                      addr_valid,
    input logic                      ddr_mode,
    input logic                      aper_hit_in,
    input logic [NUM_ROWS-1:0]       row_hit,
    input logic [IDX_W-1:0]          row_idx,
    input logic                      row_valid,
    input logic                      row_miss,
    input logic                      aper_hit_out,
    input logic                      cfg_err,
    input logic [NUM_ROWS*BND_W-1:0] bnd_flat,
    input logic                      apen
);

    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_hit));

    p_single_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && !row_miss) |-> ($countones(row_hit) == 1));

    p_miss_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_miss |-> (row_valid && (row_hit == '0) && (row_idx == '0)));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> row_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> (!row_valid && !row_miss && (row_hit == '0)));

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !apen |-> !aper_hit_out);

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        aper_hit_out |-> aper_hit_in);

    p_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ddr_mode);

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row_chk
        localparam logic [RA_W-1:0] OFS = RA_W'(int'(ROW_BASE) + r);

        p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && (reg_addr == OFS)) |=>
                (bnd_flat[r*BND_W +: BND_W] == $past(reg_wdata)));

        if (r > 0) begin : g_empty
            p_empty_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
                row_hit[r] |-> ($past(bnd_flat[r*BND_W +: BND_W]) !=
                                $past(bnd_flat[(r-1)*BND_W +: BND_W])));
        end else begin : g_first
            p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                row_hit[0] |-> ($past(bnd_flat[BND_W-1:0]) != '0));
        end
    end

endmodule

bind row_limit_decoder rowdec_checker #(
    .NUM_ROWS (NUM_ROWS),
    .BND_W    (BND_W),
    .RA_W     (RA_W),
    .ROW_BASE (ROW_BASE),
    .IDX_W    (IDX_W)
) u_chk (.*);

// File: tb/sim_row_limit_decoder.sv
`timescale 1ns/1ps
module sim_row_limit_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        addr_valid = 1'b0;
    logic [31:0] mem_addr = 32'h0;
    logic        ddr_mode = 1'b0;
    logic        aper_hit_in = 1'b0;
    logic [7:0]  row_hit;
    logic [2:0]  row_idx;
    logic        row_valid;
    logic        row_miss;
    logic        aper_hit_out;
    logic        cfg_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    row_limit_decoder u0 (.*);

    // Unit index / expected row (8 means miss) for the DDR layout 2,4,4,7,7,7,7,7
    localparam logic [6:0] VEC_U   [8] = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd4, 7'd6, 7'd7, 7'd127};
    localparam logic [3:0] VEC_ROW [8] = '{4'd0, 4'd0, 4'd1, 4'd1, 4'd3, 4'd3, 4'd8, 4'd8};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Present one address, then compare the registered result
    task automatic decode(input string req, input logic [6:0] u, input logic [3:0] exp_row);
        @(negedge clk);
        addr_valid = 1'b1;
        mem_addr   = {u, 25'h1ABCDEF};
        @(negedge clk);
        addr_valid = 1'b0;
        chk({req, " valid"}, 32'(row_valid), 32'd1);
        chk({req, " miss"}, 32'(row_miss), (exp_row == 4'd8) ? 32'd1 : 32'd0);
        chk({req, " hit"}, 32'(row_hit), (exp_row == 4'd8) ? 32'd0 : (32'd1 << exp_row));
        chk({req, " idx"}, 32'(row_idx), (exp_row == 4'd8) ? 32'd0 : 32'(exp_row));
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] bnd_a [8];
        logic [7:0] bnd_b [8];
        bnd_a = '{8'd2, 8'd4, 8'd4, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7};
        bnd_b = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd9};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(8'h60 + 8'(i), d);
            chk("R1 row reg reset", 32'(d), 32'h0);
        end
        rd(8'h51, d);
        chk("R1 ctrl reset", 32'(d), 32'h0);
        chk("R1 row_valid reset", 32'(row_valid), 32'd0);
        aper_hit_in = 1'b1;
        #1;
        chk("R1 aperture blocked at reset", 32'(aper_hit_out), 32'd0);
        aper_hit_in = 1'b0;

        // R2 program DDR layout and read it back
        for (int i = 0; i < 8; i++) wr(8'h60 + 8'(i), bnd_a[i]);
        for (int i = 0; i < 8; i++) begin
            rd(8'h60 + 8'(i), d);
            chk("R2 readback", 32'(d), 32'(bnd_a[i]));
        end

        // R9 consistent DDR layout
        ddr_mode = 1'b1;
        #1;
        chk("R9 no error when mirrored", 32'(cfg_err), 32'd0);

        // R5 / R6 / R7 vector table
        for (int k = 0; k < 8; k++) begin
            decode("R5 R6 R7 vector", VEC_U[k], VEC_ROW[k]);
        end

        // R10 idle slot after a decode
        @(negedge clk);
        chk("R10 idle valid", 32'(row_valid), 32'd0);
        chk("R10 idle hit", 32'(row_hit), 32'd0);
        chk("R10 idle miss", 32'(row_miss), 32'd0);

        // R4 back-to-back addresses
        @(negedge clk);
        addr_valid = 1'b1;
        mem_addr   = {7'd3, 25'h0};
        @(negedge clk);
        mem_addr   = {7'd5, 25'h0};
        chk("R4 first of pair", 32'(row_idx), 32'd1);
        chk("R4 first valid", 32'(row_valid), 32'd1);
        @(negedge clk);
        addr_valid = 1'b0;
        chk("R4 second of pair", 32'(row_idx), 32'd3);
        chk("R4 second valid", 32'(row_valid), 32'd1);

        // R9 mismatch in an upper row
        wr(8'h65, 8'd9);
        #1;
        chk("R9 error raised", 32'(cfg_err), 32'd1);
        ddr_mode = 1'b0;
        #1;
        chk("R9 error off outside mode", 32'(cfg_err), 32'd0);

        // Second layout: empty row 0, wide row 7
        for (int i = 0; i < 8; i++) wr(8'h60 + 8'(i), bnd_b[i]);
        decode("R6 empty row0 skipped", 7'd0, 4'd1);
        decode("R5 mid row", 7'd5, 4'd6);
        decode("R5 top row", 7'd8, 4'd7);
        decode("R7 at top limit", 7'd9, 4'd8);

        // R3 control byte and unmapped offsets
        wr(8'h51, 8'hFF);
        rd(8'h51, d);
        chk("R3 only enable bit kept", 32'(d), 32'h02);
        aper_hit_in = 1'b1;
        #1;
        chk("R8 aperture passes when enabled", 32'(aper_hit_out), 32'd1);
        aper_hit_in = 1'b0;
        #1;
        chk("R8 aperture follows input low", 32'(aper_hit_out), 32'd0);
        wr(8'h51, 8'hFD);
        rd(8'h51, d);
        chk("R3 enable cleared", 32'(d), 32'h00);
        aper_hit_in = 1'b1;
        #1;
        chk("R8 aperture blocked when disabled", 32'(aper_hit_out), 32'd0);
        aper_hit_in = 1'b0;

        wr(8'h68, 8'hAA);
        rd(8'h68, d);
        chk("R3 unmapped reads zero", 32'(d), 32'h0);
        rd(8'h67, d);
        chk("R3 neighbour untouched", 32'(d), 32'd9);
        wr(8'h5F, 8'hAA);
        rd(8'h60, d);
        chk("R3 row0 untouched", 32'(d), 32'd0);
        wr(8'h50, 8'hFF);
        rd(8'h51, d);
        chk("R3 ctrl untouched", 32'(d), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule